// File: doc/BRIEF.md
# Dual Event Counter with Monitor Pins

This block keeps two 40-bit event counters that share one control register. Each counter is set to count either occurrences, where a source may report zero, one or two hits in a clock, or durations, where it adds one for every clock in which a level condition is true. The counters can be read at any time without being stopped. Writing a counter's preset port loads a start value, so that software can set up a "count up to" limit.

Each counter drives one monitor pin. The pin can report every clock in which the counter advanced, or only the carry out of the top bit. The pin follows the internal event after a fixed register lag. A debug select input switches both pins over to show breakpoint matches instead. The counters keep running while the pins are switched over.

Top module: `pmon_pair`

## Requirements
- R1: While rst_n is low at a rising edge, both counters, the control register and the lag pipelines clear. With brk_sel low, every output reads zero after reset.
- R2: In occurrence mode, a counter adds its 2-bit hit code on each clock. The codes are 0, 1 and 2, and code 3 counts as 2.
- R3: In duration mode, a counter adds 1 on each clock in which its level input is high. The hit code is ignored in this mode.
- R4: With its enable bit clear, a counter holds its value and creates no pin event.
- R5: Counters are 40 bits wide. An addition that carries out of bit 39 wraps the counter to the sum modulo 2^40.
- R6: In increment-indicate mode, the pin is high for exactly the clocks in which the counter advanced, by 1 or by 2, delayed by LAG clocks. A run of duration clocks gives a run of high pin clocks of the same length.
- R7: In overflow-indicate mode, the pin gives a single-clock pulse, delayed by LAG clocks, for each clock in which bit 39 carried out. Ordinary increments do not show on the pin.
- R8: The control register is written whole through ctl_we and ctl_wdata, and ctl_rdata reads it back. Counter i owns bits [3i+2:3i]. Bit 3i is enable, bit 3i+1 selects duration mode (1) or occurrence mode (0), and bit 3i+2 selects overflow-indicate (1) or increment-indicate (0). A write takes effect from the next clock.
- R9: When pre_we[i] is high, counter i loads pre_val. The load wins over counting in that clock, and that clock creates no pin event.
- R10: While brk_sel is high, mon_pin follows brk_match in the same cycle. Counting and the lag pipelines go on unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hit_code | input | 2*NCTR | Occurrence hit count per counter, 2 bits each |
| dur_level | input | NCTR | Duration condition per counter |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 3*NCTR | Control register write data |
| ctl_rdata | output | 3*NCTR | Control register contents |
| pre_we | input | NCTR | Per-counter preset strobe |
| pre_val | input | CNT_W | Preset value, shared by both counters |
| brk_sel | input | 1 | Select breakpoint signalling on the pins |
| brk_match | input | NCTR | Breakpoint match per pin |
| cnt_value | output | NCTR*CNT_W | Counter values, counter i at [i*CNT_W +: CNT_W] |
| mon_pin | output | NCTR | Monitor pins |

## Verification
The bench presets counters just below 2^40 and drives hit code 2 into them, so that it catches a carry that is lost or detected from bit 38. A design that compared with 2^40-1 would miss overflows that skip over that value. Hit code 3 and back-to-back +2 clocks expose a pin that stretches or doubles its pulse, and a preset in the same clock as a hit exposes counting that wins over the load. A control write, while its old setting is still counting, catches a design that applies the new mode one clock early. Brk_sel is toggled in the middle of a pipeline to show that the lagged events neither freeze nor get lost.

// File: rtl/pmon_pkg.sv
// pmon_pkg: shared types for the dual event counter.
// Assumes each counter owns a 3-bit control field inside the shared register.
package pmon_pkg;
    localparam int FLD_W = 3;

    // Per-counter control field; en is bit 0 of the field.
    typedef struct packed {
        logic ovf_pin;   // 1: pin signals carry out, 0: pin signals increments
        logic dur;       // 1: duration mode, 0: occurrence mode
        logic en;        // counter enable
    } pmon_cfg_t;
endpackage

// File: rtl/pmon_ctlreg.sv
// pmon_ctlreg: the shared control register, written whole and read back whole.
// Assumes software does read-modify-write to change a single field.
module pmon_ctlreg #(
    parameter int CTL_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [CTL_W-1:0] wdata,
    output logic [CTL_W-1:0] q
);
    // Load the whole register on a write, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= wdata;
    end

    // R8: without a write, the register keeps its value
    p_ctl_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q));
endmodule

// File: rtl/pmon_counter.sv
// pmon_counter: one wrapping event counter with preset, plus its raw pin event.
// Assumes hit codes 0..2, with 3 treated as 2. The raw event is combinational
// and marks the clock whose edge updates the counter.
module pmon_counter
    import pmon_pkg::*;
#(
    parameter int CNT_W = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pmon_cfg_t        cfg,
    input  logic [1:0]       hits,
    input  logic             level,
    input  logic             pre_we,
    input  logic [CNT_W-1:0] pre_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             raw_evt
);
    localparam int SUM_W = CNT_W + 1;

    logic [1:0]       step;
    logic [SUM_W-1:0] sum;
    logic             carry;

    // Choose this clock's step from the mode and the inputs.
    always_comb begin
        if (!cfg.en)     step = 2'd0;
        else if (cfg.dur) step = {1'b0, level};
        else if (hits[1]) step = 2'd2;
        else             step = {1'b0, hits[0]};
    end

    // Add with one extra bit so that the carry out of the top bit is kept.
    always_comb begin
        sum   = {1'b0, cnt_q} + {{(SUM_W-2){1'b0}}, step};
        carry = sum[CNT_W];
    end

    // Raw pin event: a carry or an advance, masked by a preset.
    always_comb begin
        if (pre_we)           raw_evt = 1'b0;
        else if (cfg.ovf_pin) raw_evt = carry;
        else                  raw_evt = (step != 2'd0);
    end

    // Update the counter: a preset wins, otherwise wrap on the sum.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (pre_we) cnt_q <= pre_val;
        else             cnt_q <= sum[CNT_W-1:0];
    end

    // R4: a disabled counter without a preset holds
    p_off_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg.en && !pre_we) |=> $stable(cnt_q));

    // R3: in duration mode the counter moves by the level of the previous clock
    p_dur_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.en && cfg.dur && !pre_we && !carry) |=>
        (cnt_q - $past(cnt_q)) == {{(CNT_W-1){1'b0}}, $past(level)});

    // R5: after a carry the counter has wrapped to a small value
    p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !pre_we) |=> (cnt_q < 2));

    // R9: a preset lands as given
    p_preset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pre_we |=> (cnt_q == $past(pre_val)));
endmodule

// File: rtl/pmon_lagline.sv
// pmon_lagline: fixed-length shift pipeline that delays a pin event by DEPTH clocks.
// Assumes DEPTH >= 1. It clears on reset.
module pmon_lagline #(
    parameter int DEPTH = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [DEPTH-1:0] sr;

    generate
        if (DEPTH == 1) begin : g_one
            // Single stage: capture the event.
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '0;
                else        sr <= din;
            end
        end else begin : g_many
            // Several stages: shift the event toward the output.
            always_ff @(posedge clk) begin
                if (!rst_n) sr <= '0;
                else        sr <= {sr[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign dout = sr[DEPTH-1];
endmodule

// File: rtl/pmon_pair.sv
// pmon_pair: two event counters sharing one control register, each driving a
// monitor pin that shows lagged increments or carries, or breakpoint matches.
// Assumes the hit and level inputs are already decoded per counter.
module pmon_pair
    import pmon_pkg::*;
#(
    parameter int NCTR  = 2,
    parameter int CNT_W = 40,
    parameter int LAG   = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*NCTR-1:0]     hit_code,
    input  logic [NCTR-1:0]       dur_level,
    input  logic                  ctl_we,
    input  logic [FLD_W*NCTR-1:0] ctl_wdata,
    output logic [FLD_W*NCTR-1:0] ctl_rdata,
    input  logic [NCTR-1:0]       pre_we,
    input  logic [CNT_W-1:0]      pre_val,
    input  logic                  brk_sel,
    input  logic [NCTR-1:0]       brk_match,
    output logic [NCTR*CNT_W-1:0] cnt_value,
    output logic [NCTR-1:0]       mon_pin
);
    localparam int CTL_W = FLD_W * NCTR;

    logic [CTL_W-1:0] ctl_q;
    logic [NCTR-1:0]  raw_evt;
    logic [NCTR-1:0]  lag_out;

    pmon_ctlreg #(.CTL_W(CTL_W)) u_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctl_we),
        .wdata (ctl_wdata),
        .q     (ctl_q)
    );

    assign ctl_rdata = ctl_q;

    generate
        for (genvar i = 0; i < NCTR; i++) begin : g_ctr
            pmon_cfg_t cfg;
            assign cfg = pmon_cfg_t'(ctl_q[i*FLD_W +: FLD_W]);

            pmon_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .cfg     (cfg),
                .hits    (hit_code[2*i +: 2]),
                .level   (dur_level[i]),
                .pre_we  (pre_we[i]),
                .pre_val (pre_val),
                .cnt_q   (cnt_value[i*CNT_W +: CNT_W]),
                .raw_evt (raw_evt[i])
            );

            pmon_lagline #(.DEPTH(LAG)) u_lag (
                .clk   (clk),
                .rst_n (rst_n),
                .din   (raw_evt[i]),
                .dout  (lag_out[i])
            );
        end
    endgenerate

    // Pin source: breakpoint matches while selected, lagged events otherwise.
    always_comb begin
        mon_pin = brk_sel ? brk_match : lag_out;
    end

    // R10: with breakpoint signalling selected, the pins follow the matches
    p_brk_pins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_sel |-> (mon_pin == brk_match));
endmodule

// File: tb/pmon_pair_test.sv
`timescale 1ns/1ps
module pmon_pair_test;
    localparam int NCTR  = 2;
    localparam int CNT_W = 40;
    localparam int LAG   = 5;
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic [2*NCTR-1:0]     hit_code = '0;
    logic [NCTR-1:0]       dur_level = '0;
    logic                  ctl_we = 1'b0;
    logic [3*NCTR-1:0]     ctl_wdata = '0;
    logic [3*NCTR-1:0]     ctl_rdata;
    logic [NCTR-1:0]       pre_we = '0;
    logic [CNT_W-1:0]      pre_val = '0;
    logic                  brk_sel = 1'b0;
    logic [NCTR-1:0]       brk_match = '0;
    logic [NCTR*CNT_W-1:0] cnt_value;
    logic [NCTR-1:0]       mon_pin;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [CNT_W-1:0] m_cnt [NCTR];
    logic [LAG-1:0]   m_hist [NCTR];
    logic [3*NCTR-1:0] m_ctl;

    always #2.5 clk = ~clk;

    pmon_pair #(.NCTR(NCTR), .CNT_W(CNT_W), .LAG(LAG)) uut (
        .clk(clk), .rst_n(rst_n), .hit_code(hit_code), .dur_level(dur_level),
        .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .pre_we(pre_we), .pre_val(pre_val), .brk_sel(brk_sel),
        .brk_match(brk_match), .cnt_value(cnt_value), .mon_pin(mon_pin)
    );

    task automatic chk(input string tag, input string what,
                       input logic [CNT_W-1:0] got, input logic [CNT_W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    // Reference step computed from the requirement text (R2..R9).
    task automatic model_step();
        for (int i = 0; i < NCTR; i++) begin
            logic en, dur, ovf;
            logic [1:0] st;
            logic [CNT_W:0] s;
            logic ev;
            en  = m_ctl[3*i];
            dur = m_ctl[3*i+1];
            ovf = m_ctl[3*i+2];
            if (!en)     st = 2'd0;
            else if (dur) st = {1'b0, dur_level[i]};
            else         st = (hit_code[2*i +: 2] >= 2'd2) ? 2'd2 : hit_code[2*i +: 2];
            s = {1'b0, m_cnt[i]} + (CNT_W+1)'(st);
            if (pre_we[i]) begin
                m_cnt[i] = pre_val;
                ev = 1'b0;
            end else begin
                m_cnt[i] = s[CNT_W-1:0];
                ev = ovf ? s[CNT_W] : (st != 2'd0);
            end
            m_hist[i] = {m_hist[i][LAG-2:0], ev};
        end
        if (ctl_we) m_ctl = ctl_wdata;
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < NCTR; i++) begin
            logic pe;
            pe = brk_sel ? brk_match[i] : m_hist[i][LAG-1];
            chk(tag, $sformatf("count%0d", i), cnt_value[i*CNT_W +: CNT_W], m_cnt[i]);
            chk(tag, $sformatf("pin%0d", i), CNT_W'(mon_pin[i]), CNT_W'(pe));
        end
        chk(tag, "ctl", CNT_W'(ctl_rdata), CNT_W'(m_ctl));
    endtask

    // One clock with the inputs as currently set, then compare at the falling edge.
    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
        ctl_we = 1'b0;
        pre_we = '0;
    endtask

    task automatic idle(input string tag, input int n);
        hit_code = '0;
        dur_level = '0;
        for (int k = 0; k < n; k++) tick(tag);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got hung run expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4321));
        for (int i = 0; i < NCTR; i++) begin
            m_cnt[i] = '0;
            m_hist[i] = '0;
        end
        m_ctl = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R8: write the whole register; the old value still counts this clock
        ctl_we = 1'b1; ctl_wdata = 6'b011_001; hit_code = 4'b0101; dur_level = 2'b11;
        tick("R8");
        // R2: hit codes 1, 2, 3, 0 on counter 0; R3 duration on counter 1, hits ignored
        hit_code = 4'b1001; dur_level = 2'b10; tick("R2");
        hit_code = 4'b1110; dur_level = 2'b00; tick("R2");
        hit_code = 4'b0111; dur_level = 2'b10; tick("R3");
        hit_code = 4'b0000; dur_level = 2'b10; tick("R3");
        idle("R6", LAG + 1);

        // R9: preset wins over a hit of 2 in the same clock, with no pin event
        pre_we = 2'b01; pre_val = TOP - 40'd2; hit_code = 4'b0010; tick("R9");
        idle("R9", LAG + 1);
        // R7: overflow-indicate on counter 0, then 2+2 carries across bit 39
        ctl_we = 1'b1; ctl_wdata = 6'b011_101; tick("R7");
        hit_code = 4'b0010; tick("R5");
        hit_code = 4'b0010; tick("R5");
        hit_code = 4'b0010; tick("R7");
        idle("R7", LAG + 1);
        // R5: land exactly on 2^40-1, then carry by one
        pre_we = 2'b11; pre_val = TOP - 40'd1; tick("R5");
        hit_code = 4'b0001; dur_level = 2'b10; tick("R5");
        hit_code = 4'b0001; dur_level = 2'b10; tick("R5");
        idle("R5", LAG + 1);

        // R4: disable both, apply hits and levels, nothing moves
        ctl_we = 1'b1; ctl_wdata = 6'b110_100; tick("R4");
        for (int k = 0; k < 4; k++) begin
            hit_code = 4'b1010; dur_level = 2'b11; tick("R4");
        end
        idle("R4", LAG + 1);

        // R10: breakpoint select in the middle of pending increments
        ctl_we = 1'b1; ctl_wdata = 6'b011_001; tick("R10");
        hit_code = 4'b0001; dur_level = 2'b11; brk_sel = 1'b1; brk_match = 2'b10; tick("R10");
        hit_code = 4'b0010; brk_match = 2'b01; tick("R10");
        hit_code = 4'b0000; brk_sel = 1'b0; tick("R10");
        idle("R10", LAG + 1);

        // Random phase with occasional near-top presets and control changes
        for (int k = 0; k < 4000; k++) begin
            hit_code  = 4'($urandom);
            dur_level = 2'($urandom);
            brk_sel   = (($urandom % 8) == 0);
            brk_match = 2'($urandom);
            if (($urandom % 16) == 0) begin
                ctl_we = 1'b1;
                ctl_wdata = 6'($urandom);
            end
            if (($urandom % 24) == 0) begin
                pre_we = 2'($urandom);
                pre_val = (($urandom % 2) == 0) ? TOP - 40'($urandom % 6)
                                                : {8'($urandom), 32'($urandom)};
            end
            tick("R6");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule